// File: doc/BRIEF.md
# Codec Power-Up Register Sequencer

This block brings one audio codec, or all three at once, from reset into a running state by issuing a fixed script of nine register writes through an external serial register writer. A caller pulses a start strobe together with a target. The target is either a codec index or an "all codecs" flag. The block turns the target into a chip-select mask and walks the script one write at a time. It launches each write with a one-cycle start pulse to the writer and waits for the writer's done or error pulse before it continues.

The script is ordered on purpose. The converters are held in reset while the data format is programmed. Reset is released only after that, and then power-up, de-emphasis and the four gain settings follow. The timing of the serial line belongs entirely to the writer. This block only sequences the writes and reports the outcome as a one-cycle completion pulse or a one-cycle failure pulse.

Top module: `codec_init_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `wr_start_o`, `busy_o`, `done_o` and `fail_o` are all low.
- R2: With `all_i` set, every write carries select mask 3'b111. With `all_i` clear and a valid index n, every write carries mask `1 << n` (bit n is codec n).
- R3: A strobe with `all_i` clear and `index_i` of 3 or more issues no write and keeps `busy_o` low. It pulses `fail_o` in the cycle after the strobe.
- R4: A full run issues exactly nine writes as (register index, value) pairs, in this order: (1,0x00) holds the converters in reset; (2,0x60) sets I2S format, 256x master clock, normal speed; (1,0x03) releases both DAC and ADC; (0,0x07) powers up; (3,0x19) sets de-emphasis; then (4,0x7F), (5,0x7F), (6,0x7F), (7,0x7F) set left/right input and output gains.
- R5: Only one write is in flight at a time. After the writer's done pulse for a write that is not the last one, `wr_start_o` rises in the next cycle.
- R6: When the writer reports an error, the sequence stops. `fail_o` pulses in the next cycle, `done_o` does not pulse, and no further write is issued.
- R7: After the done for the ninth write, `done_o` pulses for one cycle in the next cycle. `busy_o` is high from the cycle after an accepted strobe until the cycle in which `done_o` or `fail_o` is high, and low in that cycle.
- R8: A start strobe that arrives while `busy_o` is high is ignored. It changes neither the mask nor the script progress.
- R9: `wr_sel_o`, `wr_addr_o` and `wr_data_o` stay stable from the cycle of `wr_start_o` until the writer answers.
- R10: If the writer raises done and error in the same cycle, the error wins and the run fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the script |
| all_i | input | 1 | Target every codec |
| index_i | input | IDX_W | Codec index used when `all_i` is clear |
| wr_start_o | output | 1 | One-cycle launch of a register write |
| wr_sel_o | output | NUM_CODECS | Codec select mask for the write |
| wr_addr_o | output | 5 | Register index for the write |
| wr_data_o | output | 8 | Register value for the write |
| wr_done_i | input | 1 | Writer finished the current write |
| wr_err_i | input | 1 | Writer failed the current write |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle pulse: all nine writes completed |
| fail_o | output | 1 | One-cycle pulse: target rejected or a write failed |

## Verification
The bench builds the block with its default values: three codecs and a two-bit index. With these values index 3 can be encoded but is out of range, so the rejection path can be reached at the ports. A behavioural writer model answers with a latency set per scenario. This covers back-to-back answers and slow ones, errors injected at the first step and in the middle of the script, and done and error raised together. It also lets the bench measure the relaunch gap and check that the address, data and select lines are held while each write is pending.

// File: rtl/codec_init_pkg.sv
// Package: script constants and types shared by the codec power-up sequencer.
// Assumes register indices fit in 5 bits and values in 8 bits.
package codec_init_pkg;

    localparam int SCRIPT_LEN = 9;
    localparam int STEP_W     = $clog2(SCRIPT_LEN);
    localparam int REG_IDX_W  = 5;
    localparam int REG_VAL_W  = 8;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [REG_IDX_W-1:0] idx;
        logic [REG_VAL_W-1:0] val;
    } script_op_t;

    // Maps a script step to its register write; the order is behaviour.
    function automatic script_op_t script_op(input logic [STEP_W-1:0] step);
        script_op_t op;
        case (step)
            4'd0:    op = '{idx: 5'd1, val: 8'h00};  // converters held in reset
            4'd1:    op = '{idx: 5'd2, val: 8'h60};  // I2S, 256x mclk, normal speed
            4'd2:    op = '{idx: 5'd1, val: 8'h03};  // DAC and ADC released
            4'd3:    op = '{idx: 5'd0, val: 8'h07};  // power up
            4'd4:    op = '{idx: 5'd3, val: 8'h19};  // de-emphasis / soft mute
            4'd5:    op = '{idx: 5'd4, val: 8'h7F};  // left input gain
            4'd6:    op = '{idx: 5'd5, val: 8'h7F};  // right input gain
            4'd7:    op = '{idx: 5'd6, val: 8'h7F};  // left output gain
            default: op = '{idx: 5'd7, val: 8'h7F};  // right output gain
        endcase
        return op;
    endfunction

endpackage

// File: rtl/codec_target_dec.sv
// Target decoder: turns the caller's target (index or "all") into a codec
// select mask and a validity flag. Purely combinational.
// Assumes index values at or above NUM_CODECS are invalid unless all_i is set.
module codec_target_dec #(
    parameter int NUM_CODECS = 3,
    parameter int IDX_W      = 2
) (
    input  logic                  all_i,
    input  logic [IDX_W-1:0]      index_i,
    output logic [NUM_CODECS-1:0] mask_o,
    output logic                  valid_o
);

    // Validity: "all" is always accepted, an index only when in range.
    always_comb begin
        valid_o = all_i || (int'(index_i) < NUM_CODECS);
    end

    // One mask bit per codec, set for "all" or a matching index.
    for (genvar g = 0; g < NUM_CODECS; g++) begin : g_mask
        assign mask_o[g] = all_i || (index_i == IDX_W'(g));
    end

endmodule

// File: rtl/codec_script_rom.sv
// Script table: returns the register index and value for a step.
// Assumes the step counter never exceeds SCRIPT_LEN-1.
module codec_script_rom
    import codec_init_pkg::*;
(
    input  logic [STEP_W-1:0]    step_i,
    output logic [REG_IDX_W-1:0] idx_o,
    output logic [REG_VAL_W-1:0] val_o
);

    script_op_t op;

    // Table lookup through the package function.
    always_comb begin
        op    = script_op(step_i);
        idx_o = op.idx;
        val_o = op.val;
    end

endmodule

// File: rtl/codec_seq_ctrl.sv
// Sequence controller: accepts a start, latches the mask, launches one write
// at a time and advances on the writer's done. It stops on the writer's error.
// Assumes the writer never answers in the same cycle as its start pulse.
module codec_seq_ctrl
    import codec_init_pkg::*;
#(
    parameter int NUM_CODECS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  target_ok_i,
    input  logic [NUM_CODECS-1:0] target_mask_i,
    input  logic                  wr_done_i,
    input  logic                  wr_err_i,
    output logic                  wr_start_o,
    output logic [NUM_CODECS-1:0] sel_o,
    output logic [STEP_W-1:0]     step_o,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  fail_o
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SCRIPT_LEN - 1);

    seq_state_t            state_q;
    logic [STEP_W-1:0]     step_q;
    logic [NUM_CODECS-1:0] mask_q;
    logic                  done_q;
    logic                  fail_q;

    // State, step counter, mask latch and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            step_q  <= '0;
            mask_q  <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        if (target_ok_i) begin
                            mask_q  <= target_mask_i;
                            step_q  <= '0;
                            state_q <= SQ_ISSUE;
                        end else begin
                            fail_q <= 1'b1;
                        end
                    end
                end
                SQ_ISSUE: begin
                    state_q <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (wr_err_i) begin
                        fail_q  <= 1'b1;
                        state_q <= SQ_IDLE;
                    end else if (wr_done_i) begin
                        if (step_q == LAST_STEP) begin
                            done_q  <= 1'b1;
                            state_q <= SQ_IDLE;
                        end else begin
                            step_q  <= step_q + 1'b1;
                            state_q <= SQ_ISSUE;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Output decode from registered state.
    always_comb begin
        wr_start_o = (state_q == SQ_ISSUE);
        busy_o     = (state_q != SQ_IDLE);
        sel_o      = mask_q;
        step_o     = step_q;
        done_o     = done_q;
        fail_o     = fail_q;
    end

    p_err_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && wr_err_i) |=> (fail_o && !busy_o && !done_o));

    p_err_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && wr_err_i && wr_done_i) |=> !wr_start_o);

    p_relaunch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && wr_done_i && !wr_err_i && step_q != LAST_STEP)
        |=> wr_start_o);

    p_single_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_o |=> !wr_start_o);

    p_final_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WAIT && wr_done_i && !wr_err_i && step_q == LAST_STEP)
        |=> (done_o && !busy_o));

    p_pulse_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |=> !(done_o || fail_o) || !busy_o);

    p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(mask_q));

endmodule

// File: rtl/codec_init_seq.sv
// Codec power-up sequencer top: decodes the target, runs the nine-step script
// through an external register writer and reports done or fail pulses.
// Assumes the writer holds no state visible here besides done and error.
module codec_init_seq
    import codec_init_pkg::*;
#(
    parameter int NUM_CODECS = 3,
    parameter int IDX_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  all_i,
    input  logic [IDX_W-1:0]      index_i,
    output logic                  wr_start_o,
    output logic [NUM_CODECS-1:0] wr_sel_o,
    output logic [REG_IDX_W-1:0]  wr_addr_o,
    output logic [REG_VAL_W-1:0]  wr_data_o,
    input  logic                  wr_done_i,
    input  logic                  wr_err_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  fail_o
);

    logic [NUM_CODECS-1:0] tgt_mask;
    logic                  tgt_ok;
    logic [STEP_W-1:0]     step;

    codec_target_dec #(
        .NUM_CODECS (NUM_CODECS),
        .IDX_W      (IDX_W)
    ) u_dec (
        .all_i   (all_i),
        .index_i (index_i),
        .mask_o  (tgt_mask),
        .valid_o (tgt_ok)
    );

    codec_seq_ctrl #(
        .NUM_CODECS (NUM_CODECS)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .target_ok_i   (tgt_ok),
        .target_mask_i (tgt_mask),
        .wr_done_i     (wr_done_i),
        .wr_err_i      (wr_err_i),
        .wr_start_o    (wr_start_o),
        .sel_o         (wr_sel_o),
        .step_o        (step),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .fail_o        (fail_o)
    );

    codec_script_rom u_rom (
        .step_i (step),
        .idx_o  (wr_addr_o),
        .val_o  (wr_data_o)
    );

    p_sel_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_o |-> (wr_sel_o != '0));

    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !all_i && int'(index_i) >= NUM_CODECS)
        |=> (fail_o && !busy_o && !wr_start_o));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !wr_start_o) |-> ($stable(wr_addr_o) && $stable(wr_data_o)
                                     && $stable(wr_sel_o)));

endmodule

// File: tb/codec_init_seq_bench.sv
module codec_init_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       all_sel = 1'b0;
    logic [1:0] idx = '0;
    logic       wr_start;
    logic [2:0] wr_sel;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;
    logic       wr_done = 1'b0;
    logic       wr_err = 1'b0;
    logic       busy, done, fail;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    codec_init_seq u_codec_init_seq (
        .clk (clk), .rst_n (rst_n), .start_i (start), .all_i (all_sel),
        .index_i (idx), .wr_start_o (wr_start), .wr_sel_o (wr_sel),
        .wr_addr_o (wr_addr), .wr_data_o (wr_data), .wr_done_i (wr_done),
        .wr_err_i (wr_err), .busy_o (busy), .done_o (done), .fail_o (fail)
    );

    // Writer model settings, driven by the scenario tasks.
    int lat = 1;
    int err_at = -1;
    bit both_at_err = 0;
    // Writer model log.
    int wr_cnt = 0;
    logic [4:0] log_addr [16];
    logic [7:0] log_data [16];
    logic [2:0] log_sel  [16];
    int hold_bad = 0;
    int gap_bad = 0;
    int overlap = 0;
    int since = 0;
    int cnt = 0;
    bit pend = 0;

    always @(posedge clk) begin
        wr_done <= 1'b0;
        wr_err  <= 1'b0;
        since   <= since + 1;
        if (wr_start) begin
            if (pend) overlap <= overlap + 1;
            if (wr_cnt > 0 && since != 1) gap_bad <= gap_bad + 1;
            if (wr_cnt < 16) begin
                log_addr[wr_cnt] <= wr_addr;
                log_data[wr_cnt] <= wr_data;
                log_sel[wr_cnt]  <= wr_sel;
            end
            wr_cnt <= wr_cnt + 1;
            pend   <= 1'b1;
            cnt    <= lat;
        end else if (pend) begin
            if (cnt <= 1) begin
                pend <= 1'b0;
                since <= 0;
                if (wr_cnt >= 1 && wr_cnt <= 16) begin
                    if (wr_addr != log_addr[wr_cnt-1] || wr_data != log_data[wr_cnt-1]
                        || wr_sel != log_sel[wr_cnt-1])
                        hold_bad <= hold_bad + 1;
                end
                if (wr_cnt - 1 == err_at) begin
                    wr_err <= 1'b1;
                    if (both_at_err) wr_done <= 1'b1;
                end else begin
                    wr_done <= 1'b1;
                end
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [12:0] exp_op(input int k);
        case (k)
            0: return {5'd1, 8'h00};
            1: return {5'd2, 8'h60};
            2: return {5'd1, 8'h03};
            3: return {5'd0, 8'h07};
            4: return {5'd3, 8'h19};
            5: return {5'd4, 8'h7F};
            6: return {5'd5, 8'h7F};
            7: return {5'd6, 8'h7F};
            default: return {5'd7, 8'h7F};
        endcase
    endfunction

    // Results of the last run.
    int got_done, got_fail, busy_gap, extra_pulses, writes_at_end;
    bit first_busy;

    // Runs one request and collects the outcome; optional strobe while busy.
    task automatic run(input bit a, input logic [1:0] n, input int l, input int ea,
                       input bit both, input bit poke);
        @(negedge clk);
        lat = l; err_at = ea; both_at_err = both;
        wr_cnt = 0; hold_bad = 0; gap_bad = 0; overlap = 0;
        got_done = 0; got_fail = 0; busy_gap = 0; extra_pulses = 0;
        all_sel = a; idx = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first_busy = busy;
        for (int c = 0; c < 400; c++) begin
            if (done || fail) begin
                got_done = done; got_fail = fail;
                if (busy) busy_gap++;
                break;
            end
            if (!busy) busy_gap++;
            if (poke && c == 5) begin
                all_sel = 1'b0; idx = 2'd0; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        writes_at_end = wr_cnt;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done || fail) extra_pulses++;
        end
    endtask

    function automatic int script_bad();
        int bad = 0;
        for (int k = 0; k < 9; k++)
            if ({log_addr[k], log_data[k]} != exp_op(k)) bad++;
        return bad;
    endfunction

    function automatic int sel_bad(input logic [2:0] m, input int cnt_w);
        int bad = 0;
        for (int k = 0; k < cnt_w && k < 16; k++)
            if (log_sel[k] != m) bad++;
        return bad;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check(!wr_start && !busy && !done && !fail, "R1 outputs in reset",
              {wr_start, busy, done, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_start && !busy && !done && !fail, "R1 outputs after reset",
              {wr_start, busy, done, fail}, 0);
    endtask

    task automatic t_all();
        run(1'b1, 2'd0, 1, -1, 0, 0);
        check(wr_cnt == 9, "R4 write count", wr_cnt, 9);
        check(script_bad() == 0, "R4 script order", script_bad(), 0);
        check(sel_bad(3'b111, 9) == 0, "R2 all mask", sel_bad(3'b111, 9), 0);
        check(got_done == 1 && got_fail == 0, "R7 done pulse", got_done, 1);
        check(first_busy && busy_gap == 0, "R7 busy window", busy_gap, 0);
        check(extra_pulses == 0, "R7 single pulse", extra_pulses, 0);
        check(gap_bad == 0 && overlap == 0, "R5 relaunch timing", gap_bad + overlap, 0);
        check(hold_bad == 0, "R9 lines held", hold_bad, 0);
    endtask

    task automatic t_single(input logic [1:0] n, input int l);
        run(1'b0, n, l, -1, 0, 0);
        check(sel_bad(3'b001 << n, 9) == 0, "R2 single mask", int'(log_sel[0]), 1 << n);
        check(wr_cnt == 9 && script_bad() == 0, "R4 script single", script_bad(), 0);
        check(got_done == 1, "R7 done single", got_done, 1);
        check(gap_bad == 0 && overlap == 0, "R5 slow writer", gap_bad + overlap, 0);
        check(hold_bad == 0, "R9 lines held slow", hold_bad, 0);
    endtask

    task automatic t_invalid();
        run(1'b0, 2'd3, 1, -1, 0, 0);
        check(wr_cnt == 0, "R3 no write", wr_cnt, 0);
        check(got_fail == 1 && got_done == 0, "R3 fail pulse", got_fail, 1);
        check(!first_busy, "R3 busy low", first_busy, 0);
    endtask

    task automatic t_error(input int ea, input bit both, input string req);
        run(1'b1, 2'd0, 2, ea, both, 0);
        check(got_fail == 1 && got_done == 0, {req, " fail"}, got_fail, 1);
        check(wr_cnt == ea + 1, {req, " writes stop"}, wr_cnt, ea + 1);
        check(extra_pulses == 0, {req, " no later pulse"}, extra_pulses, 0);
    endtask

    task automatic t_busy_ignore();
        run(1'b1, 2'd0, 1, -1, 0, 1);
        check(wr_cnt == 9, "R8 write count", wr_cnt, 9);
        check(sel_bad(3'b111, 9) == 0, "R8 mask kept", sel_bad(3'b111, 9), 0);
        check(script_bad() == 0 && got_done == 1, "R8 run intact", script_bad(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_all();
        t_single(2'd0, 1);
        t_single(2'd1, 4);
        t_single(2'd2, 2);
        t_invalid();
        t_error(0, 0, "R6 first step");
        t_error(4, 0, "R6 mid script");
        t_error(2, 1, "R10 done with error");
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule